// File: doc/BRIEF.md
# Interrupt-Controller Register Write Validator

This block sits on the write path of a local interrupt controller. Each 64-bit write names a register by a 12-bit index. The block checks the reserved bits of that register and either stores the value, raises a fault, or drops the write as unsupported. Three indices hold narrow or write-only registers: a priority level, a self-interrupt vector, and an acknowledge register that must always be written with zero.

The fourth index is the interrupt-command register, and a write to it has three possible outcomes. If a reserved bit is set, the write faults. If the write is a plain physical, edge-triggered, fixed-delivery, unicast command, it becomes a fast-path inter-processor interrupt request that carries a vector and a destination ID. Any other command produces a one-cycle trap pulse so that slower logic can emulate it. Bit 12 of the command register never disqualifies a write as a fault, but it does rule out the fast path, and it always reads back as zero.

A fast-path request is held on a valid/ready port. New writes stall until that request is taken.

Top module: `apic_wr_validator`

## Requirements
- R1: A write to the command index (830h) faults when any of data bits 31:20, 17:16 or 13 is 1.
- R2: A write to the level index (808h) or the self-vector index (83Fh) faults when data bits 63:32 or 31:8 are nonzero.
- R3: A write to the acknowledge index (80Bh) faults when any data bit is 1.
- R4: A faulting write leaves every stored register unchanged, and `fault_pulse` is high for exactly the one cycle after the accepting edge.
- R5: A non-faulting command write with bits 19:18=00, bit 15=0, bit 12=0, bit 11=0 and bits 10:8=000 raises `ipi_valid` in the cycle after acceptance. `ipi_vector` is data bits 7:0 and `ipi_dest` is data bits 63:32.
- R6: A non-faulting command write that fails any condition of R5 stores the value and pulses `trap_pulse` for one cycle. While the pulse is high, `trap_cmd` already shows the stored value.
- R7: Bit 12 of the stored command value reads back as 0, and also shows as 0 on `trap_cmd`.
- R8: While `ipi_valid` is high, `wr_ready` is low and the vector and destination stay stable. The request clears on the cycle after an edge where `ipi_ready` is high.
- R9: A write to any other index changes no stored register and pulses `unsup_pulse` for one cycle.
- R10: While `rst_n` is low at a clock edge, all stored registers, the pending request and all pulses clear.
- R11: Read-back on `rd_idx` is combinational. The level and self-vector registers return their 8 stored bits zero-extended. The acknowledge index and unsupported indices return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write can be accepted (low while a fast-path request is pending) |
| wr_idx | input | 12 | Register index of the write |
| wr_data | input | 64 | Write value |
| rd_idx | input | 12 | Register index for read-back |
| rd_data | output | 64 | Read-back value |
| fault_pulse | output | 1 | Reserved-bit fault, one cycle |
| unsup_pulse | output | 1 | Unsupported index, one cycle |
| trap_pulse | output | 1 | Command needs slow-path handling, one cycle |
| trap_cmd | output | 64 | Stored command value |
| ipi_valid | output | 1 | Fast-path interrupt request pending |
| ipi_ready | input | 1 | Consumer takes the fast-path request |
| ipi_vector | output | 8 | Vector of the pending request |
| ipi_dest | output | 32 | Destination ID of the pending request |

## Verification
The bench builds the block with its default parameters: a 12-bit index, the four standard register indices and 8-bit narrow registers. With these values every documented bit position is reachable. The random data is biased so that each reserved field and each fast-path disqualifier is often zero and sometimes set. This produces a mix of faults, fast-path requests and traps for every command-bit combination, and lets unsupported indices land next to the real ones.

// File: rtl/apic_wv_pkg.sv
// Package: shared constants and types for the register write validator.
// Assumes a 64-bit write bus; the bit positions below are fixed by the
// command-register layout that downstream interrupt logic decodes.
package apic_wv_pkg;

    localparam int DATA_W   = 64;
    localparam int VEC_W    = 8;
    localparam int DEST_W   = 32;
    localparam int DEST_LSB = 32;
    localparam int BUSY_BIT = 12;

    // Command bits that must be zero or the write faults.
    localparam logic [DATA_W-1:0] CMD_RESV_MASK = 64'h0000_0000_FFF3_2000;
    // Command bits that must be zero for the fast path.
    localparam logic [DATA_W-1:0] CMD_SLOW_MASK = 64'h0000_0000_000C_9F00;
    // Bit that is never stored.
    localparam logic [DATA_W-1:0] BUSY_MASK     = 64'h1 << BUSY_BIT;

    typedef enum logic [2:0] {
        WR_NONE,
        WR_STORE,
        WR_FAULT,
        WR_UNSUP,
        WR_IPI,
        WR_TRAP
    } wr_outcome_e;

    typedef enum logic [1:0] {
        SEL_CMD,
        SEL_LEVEL,
        SEL_SELF,
        SEL_ACK
    } reg_sel_e;

endpackage

// File: rtl/apic_wv_decode.sv
// Module: apic_wv_decode
// Classifies one write by index and data into an outcome and a register
// select. Purely combinational; the caller gates the result with its own
// accept strobe.
module apic_wv_decode
    import apic_wv_pkg::*;
#(
    parameter int          IDX_W     = 12,
    parameter int unsigned CMD_IDX   = 'h830,
    parameter int unsigned LEVEL_IDX = 'h808,
    parameter int unsigned SELF_IDX  = 'h83F,
    parameter int unsigned ACK_IDX   = 'h80B,
    parameter int          NARROW_W  = 8
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] data,
    output wr_outcome_e       outcome,
    output reg_sel_e          sel
);

    localparam logic [DATA_W-1:0] NARROW_RESV = {DATA_W{1'b1}} << NARROW_W;

    logic cmd_resv;
    logic cmd_slow;
    logic narrow_resv;
    logic any_set;

    // Reserved-field and fast-path qualifier terms.
    always_comb begin
        cmd_resv    = |(data & CMD_RESV_MASK);
        cmd_slow    = |(data & CMD_SLOW_MASK);
        narrow_resv = |(data & NARROW_RESV);
        any_set     = |data;
    end

    // Index match and outcome selection.
    always_comb begin
        sel     = SEL_CMD;
        outcome = WR_UNSUP;
        if (idx == IDX_W'(CMD_IDX)) begin
            sel = SEL_CMD;
            if (cmd_resv)      outcome = WR_FAULT;
            else if (cmd_slow) outcome = WR_TRAP;
            else               outcome = WR_IPI;
        end else if (idx == IDX_W'(LEVEL_IDX)) begin
            sel     = SEL_LEVEL;
            outcome = narrow_resv ? WR_FAULT : WR_STORE;
        end else if (idx == IDX_W'(SELF_IDX)) begin
            sel     = SEL_SELF;
            outcome = narrow_resv ? WR_FAULT : WR_STORE;
        end else if (idx == IDX_W'(ACK_IDX)) begin
            sel     = SEL_ACK;
            outcome = any_set ? WR_FAULT : WR_STORE;
        end
    end

endmodule

// File: rtl/apic_wv_regfile.sv
// Module: apic_wv_regfile
// Holds the command register (bit 12 forced to zero) and the narrow
// registers, and serves combinational read-back. Assumes write enables
// are already qualified (no faults reach here).
module apic_wv_regfile
    import apic_wv_pkg::*;
#(
    parameter int          IDX_W     = 12,
    parameter int unsigned CMD_IDX   = 'h830,
    parameter int unsigned LEVEL_IDX = 'h808,
    parameter int unsigned SELF_IDX  = 'h83F,
    parameter int          NARROW_W  = 8,
    parameter int          NARROW_N  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_cmd,
    input  logic [NARROW_N-1:0] we_narrow,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [DATA_W-1:0]   rd_data,
    output logic [DATA_W-1:0]   cmd_q
);

    logic [NARROW_W-1:0] narrow_q [NARROW_N];

    // Command register storage; the busy position is never kept.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q <= '0;
        else if (we_cmd) cmd_q <= wdata & ~BUSY_MASK;
    end

    // One narrow register per slot (0 = level, 1 = self-vector).
    for (genvar g = 0; g < NARROW_N; g++) begin : g_narrow
        always_ff @(posedge clk) begin
            if (!rst_n)          narrow_q[g] <= '0;
            else if (we_narrow[g]) narrow_q[g] <= wdata[NARROW_W-1:0];
        end
    end

    // Read-back mux; unlisted indices return zero.
    always_comb begin
        rd_data = '0;
        if (rd_idx == IDX_W'(CMD_IDX))        rd_data = cmd_q;
        else if (rd_idx == IDX_W'(LEVEL_IDX)) rd_data = DATA_W'(narrow_q[0]);
        else if (rd_idx == IDX_W'(SELF_IDX))  rd_data = DATA_W'(narrow_q[1]);
    end

endmodule

// File: rtl/apic_wv_ipi_slot.sv
// Module: apic_wv_ipi_slot
// One-entry holding slot for a fast-path interrupt request on a
// valid/ready port. Assumes load is only asserted while the slot is empty.
module apic_wv_ipi_slot #(
    parameter int VEC_W  = 8,
    parameter int DEST_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [VEC_W-1:0]  vec_in,
    input  logic [DEST_W-1:0] dest_in,
    input  logic              ready,
    output logic              valid,
    output logic [VEC_W-1:0]  vec,
    output logic [DEST_W-1:0] dest
);

    // Fill on load, drain on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            vec   <= '0;
            dest  <= '0;
        end else if (load) begin
            valid <= 1'b1;
            vec   <= vec_in;
            dest  <= dest_in;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end

endmodule

// File: rtl/apic_wr_validator.sv
// Module: apic_wr_validator
// Top of the register write validator. Accepts a write when no fast-path
// request is pending, classifies it, updates storage and emits one-cycle
// fault / unsupported / trap pulses in the cycle after acceptance.
module apic_wr_validator
    import apic_wv_pkg::*;
#(
    parameter int          IDX_W     = 12,
    parameter int unsigned CMD_IDX   = 'h830,
    parameter int unsigned LEVEL_IDX = 'h808,
    parameter int unsigned SELF_IDX  = 'h83F,
    parameter int unsigned ACK_IDX   = 'h80B,
    parameter int          NARROW_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [63:0]       wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [63:0]       rd_data,
    output logic              fault_pulse,
    output logic              unsup_pulse,
    output logic              trap_pulse,
    output logic [63:0]       trap_cmd,
    output logic              ipi_valid,
    input  logic              ipi_ready,
    output logic [7:0]        ipi_vector,
    output logic [31:0]       ipi_dest
);

    localparam int NARROW_N = 2;

    wr_outcome_e         outcome;
    reg_sel_e            sel;
    logic                accept;
    logic                we_cmd;
    logic [NARROW_N-1:0] we_narrow;
    logic                ipi_load;

    apic_wv_decode #(
        .IDX_W(IDX_W), .CMD_IDX(CMD_IDX), .LEVEL_IDX(LEVEL_IDX),
        .SELF_IDX(SELF_IDX), .ACK_IDX(ACK_IDX), .NARROW_W(NARROW_W)
    ) u_decode (
        .idx     (wr_idx),
        .data    (wr_data),
        .outcome (outcome),
        .sel     (sel)
    );

    // Accept strobe and per-register write enables.
    always_comb begin
        wr_ready     = !ipi_valid;
        accept       = wr_valid && wr_ready;
        we_cmd       = accept && (outcome == WR_IPI || outcome == WR_TRAP);
        ipi_load     = accept && (outcome == WR_IPI);
        we_narrow[0] = accept && (outcome == WR_STORE) && (sel == SEL_LEVEL);
        we_narrow[1] = accept && (outcome == WR_STORE) && (sel == SEL_SELF);
    end

    apic_wv_regfile #(
        .IDX_W(IDX_W), .CMD_IDX(CMD_IDX), .LEVEL_IDX(LEVEL_IDX),
        .SELF_IDX(SELF_IDX), .NARROW_W(NARROW_W), .NARROW_N(NARROW_N)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_cmd    (we_cmd),
        .we_narrow (we_narrow),
        .wdata     (wr_data),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .cmd_q     (trap_cmd)
    );

    apic_wv_ipi_slot #(.VEC_W(VEC_W), .DEST_W(DEST_W)) u_ipi (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ipi_load),
        .vec_in  (wr_data[VEC_W-1:0]),
        .dest_in (wr_data[DEST_LSB +: DEST_W]),
        .ready   (ipi_ready),
        .valid   (ipi_valid),
        .vec     (ipi_vector),
        .dest    (ipi_dest)
    );

    // One-cycle outcome pulses for the accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_pulse <= 1'b0;
            unsup_pulse <= 1'b0;
            trap_pulse  <= 1'b0;
        end else begin
            fault_pulse <= accept && (outcome == WR_FAULT);
            unsup_pulse <= accept && (outcome == WR_UNSUP);
            trap_pulse  <= accept && (outcome == WR_TRAP);
        end
    end

endmodule

// File: rtl/apic_wr_validator_chk.sv
// Module: apic_wr_validator_chk
// Protocol checker bound into apic_wr_validator; observes ports only.
module apic_wr_validator_chk #(
    parameter int          IDX_W   = 12,
    parameter int unsigned CMD_IDX = 'h830,
    parameter int unsigned ACK_IDX = 'h80B
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_valid,
    input logic             wr_ready,
    input logic [63:0]      wr_data,
    input logic [IDX_W-1:0] rd_idx,
    input logic [63:0]      rd_data,
    input logic             fault_pulse,
    input logic             unsup_pulse,
    input logic             trap_pulse,
    input logic [63:0]      trap_cmd,
    input logic             ipi_valid,
    input logic             ipi_ready,
    input logic [7:0]       ipi_vector,
    input logic [31:0]      ipi_dest
);

    AST_FAULT_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |-> $past(wr_valid && wr_ready)); // R4

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fault_pulse, unsup_pulse, trap_pulse})); // R6

    AST_TRAP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> (trap_cmd == ($past(wr_data) & ~(64'h1 << 12)))); // R6

    AST_BUSY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == IDX_W'(CMD_IDX)) |-> !rd_data[12]); // R7

    AST_STALL_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        ipi_valid |-> !wr_ready); // R8

    AST_IPI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ipi_valid && !ipi_ready) |=> (ipi_valid && $stable(ipi_vector) && $stable(ipi_dest))); // R8

    AST_IPI_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (ipi_valid && ipi_ready) |=> !ipi_valid); // R8

    AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == IDX_W'(ACK_IDX)) |-> (rd_data == 64'h0)); // R11

endmodule

bind apic_wr_validator apic_wr_validator_chk #(
    .IDX_W(IDX_W), .CMD_IDX(CMD_IDX), .ACK_IDX(ACK_IDX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .fault_pulse(fault_pulse), .unsup_pulse(unsup_pulse),
    .trap_pulse(trap_pulse), .trap_cmd(trap_cmd), .ipi_valid(ipi_valid),
    .ipi_ready(ipi_ready), .ipi_vector(ipi_vector), .ipi_dest(ipi_dest)
);

// File: tb/apic_wr_validator_tb.sv
`timescale 1ns/1ps
module apic_wr_validator_tb;

    localparam logic [11:0] I_CMD = 12'h830, I_LVL = 12'h808,
                            I_SLF = 12'h83F, I_ACK = 12'h80B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [11:0] wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic [11:0] rd_idx = '0;
    logic [63:0] rd_data;
    logic        fault_pulse, unsup_pulse, trap_pulse, ipi_valid;
    logic        ipi_ready = 1'b0;
    logic [63:0] trap_cmd;
    logic [7:0]  ipi_vector;
    logic [31:0] ipi_dest;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [63:0] m_cmd = '0;
    logic [7:0]  m_lvl = '0, m_slf = '0;

    always #2 clk = ~clk;

    apic_wr_validator u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .fault_pulse(fault_pulse), .unsup_pulse(unsup_pulse),
        .trap_pulse(trap_pulse), .trap_cmd(trap_cmd), .ipi_valid(ipi_valid),
        .ipi_ready(ipi_ready), .ipi_vector(ipi_vector), .ipi_dest(ipi_dest)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected classification: 0 store, 1 fault, 2 unsupported, 3 ipi, 4 trap.
    function automatic int classify(input logic [11:0] idx, input logic [63:0] d);
        if (idx == I_CMD) begin
            if (d[31:20] != 0 || d[17:16] != 0 || d[13]) return 1;
            if (d[19:18] == 0 && !d[15] && !d[12] && !d[11] && d[10:8] == 0) return 3;
            return 4;
        end
        if (idx == I_LVL || idx == I_SLF) return (d[63:8] != 0) ? 1 : 0;
        if (idx == I_ACK) return (d != 0) ? 1 : 0;
        return 2;
    endfunction

    task automatic check_reads(input string req);
        rd_idx = I_CMD; #0.1;
        chk(rd_data == m_cmd, {req, " cmd readback"}, rd_data, m_cmd);
        rd_idx = I_LVL; #0.1;
        chk(rd_data == {56'h0, m_lvl}, {req, " level readback R11"}, rd_data, {56'h0, m_lvl});
        rd_idx = I_SLF; #0.1;
        chk(rd_data == {56'h0, m_slf}, {req, " self readback R11"}, rd_data, {56'h0, m_slf});
        rd_idx = I_ACK; #0.1;
        chk(rd_data == 64'h0, "R11 ack readback", rd_data, 64'h0);
    endtask

    // Issue one write from a negedge, check outcome at the following negedge.
    task automatic do_write(input logic [11:0] idx, input logic [63:0] d);
        int c;
        c = classify(idx, d);
        wr_idx = idx; wr_data = d; wr_valid = 1'b1;
        @(posedge clk); #1; wr_valid = 1'b0;
        if (c == 0) begin
            if (idx == I_LVL) m_lvl = d[7:0];
            if (idx == I_SLF) m_slf = d[7:0];
        end
        if (c == 3 || c == 4) m_cmd = d & ~(64'h1 << 12);
        @(negedge clk);
        chk(fault_pulse == (c == 1), "R1/R2/R3 fault pulse", {63'h0, fault_pulse}, {63'h0, c == 1});
        chk(unsup_pulse == (c == 2), "R9 unsupported pulse", {63'h0, unsup_pulse}, {63'h0, c == 2});
        chk(trap_pulse == (c == 4), "R6 trap pulse", {63'h0, trap_pulse}, {63'h0, c == 4});
        chk(ipi_valid == (c == 3), "R5 ipi valid", {63'h0, ipi_valid}, {63'h0, c == 3});
        if (c == 4) chk(trap_cmd == m_cmd, "R6 R7 trap value", trap_cmd, m_cmd);
        check_reads(c == 1 ? "R4" : (c == 2 ? "R9" : "R7"));
        if (c == 3) begin
            chk(ipi_vector == d[7:0], "R5 vector", {56'h0, ipi_vector}, {56'h0, d[7:0]});
            chk(ipi_dest == d[63:32], "R5 dest", {32'h0, ipi_dest}, {32'h0, d[63:32]});
            chk(!wr_ready, "R8 stall", {63'h0, wr_ready}, 64'h0);
            @(negedge clk);
            chk(ipi_valid && ipi_vector == d[7:0], "R8 hold", {63'h0, ipi_valid}, 64'h1);
            ipi_ready = 1'b1;
            @(posedge clk); #1; ipi_ready = 1'b0;
            @(negedge clk);
            chk(!ipi_valid && wr_ready, "R8 drain", {62'h0, ipi_valid, wr_ready}, 64'h1);
        end else begin
            @(negedge clk);
            chk(!fault_pulse && !trap_pulse && !unsup_pulse, "R4 pulse width",
                {61'h0, fault_pulse, trap_pulse, unsup_pulse}, 64'h0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] d;
        logic [11:0] idx;
        int unsigned sel;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state.
        chk(wr_ready && !ipi_valid && !fault_pulse && !trap_pulse && !unsup_pulse,
            "R10 reset outputs", {59'h0, wr_ready, ipi_valid, fault_pulse, trap_pulse, unsup_pulse}, 64'h10);
        check_reads("R10");

        // Directed corners.
        do_write(I_CMD, 64'h0000_0000_0000_1000);      // R7: only bit 12 -> trap, reads 0
        do_write(I_CMD, 64'h0000_0000_0000_20FF);      // R1: bit 13 faults, R4 unchanged
        do_write(I_CMD, 64'h0000_0000_0001_0000);      // R1: bit 16
        do_write(I_CMD, 64'h0000_0000_8000_0000);      // R1: bit 31
        do_write(I_CMD, 64'hDEAD_BEEF_0000_0041);      // R5 fast path
        do_write(I_CMD, 64'h1234_5678_0004_0041);      // R6 shorthand set
        do_write(I_CMD, 64'h1234_5678_0000_0141);      // R6 delivery mode
        do_write(I_LVL, 64'h0000_0000_0000_00A5);      // R2 store
        do_write(I_LVL, 64'h0000_0001_0000_0011);      // R2 high word fault
        do_write(I_SLF, 64'h0000_0000_0000_0133);      // R2 bit 8 fault
        do_write(I_SLF, 64'h0000_0000_0000_005C);      // R2 store
        do_write(I_ACK, 64'h0);                        // R3 zero ok
        do_write(I_ACK, 64'h8000_0000_0000_0000);      // R3 fault
        do_write(12'h831, 64'hFFFF_FFFF_FFFF_FFFF);    // R9

        // R8: a write held while a request is pending is not taken.
        do_write(I_CMD, 64'h0000_0007_0000_0099);
        wr_idx = 12'h000; wr_data = 64'h1; wr_valid = 1'b1;
        d = 64'hAAAA_0000_0000_0022;
        wr_idx = I_CMD; wr_data = d;   // fast path, pending
        @(posedge clk); #1;
        @(negedge clk);
        chk(ipi_valid && !wr_ready, "R8 pending with write held", {62'h0, ipi_valid, wr_ready}, 64'h2);
        wr_idx = 12'h7FF;              // unsupported index waiting
        repeat (2) @(negedge clk);
        chk(!unsup_pulse && ipi_vector == 8'h22, "R8 held write not taken", {63'h0, unsup_pulse}, 64'h0);
        ipi_ready = 1'b1;
        @(posedge clk); #1; ipi_ready = 1'b0;   // drained here; held write taken next edge
        @(posedge clk); #1; wr_valid = 1'b0;
        @(negedge clk);
        chk(unsup_pulse, "R9 held write taken after drain", {63'h0, unsup_pulse}, 64'h1);
        m_cmd = d;
        @(negedge clk);

        // R10: reset with a request pending.
        do_write(I_LVL, 64'h77);
        wr_idx = I_CMD; wr_data = 64'h0000_0003_0000_0010; wr_valid = 1'b1;
        @(posedge clk); #1; wr_valid = 1'b0; rst_n = 1'b0;
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        m_cmd = '0; m_lvl = '0; m_slf = '0;
        chk(!ipi_valid && wr_ready, "R10 pending cleared", {62'h0, ipi_valid, wr_ready}, 64'h1);
        check_reads("R10");

        // Constrained random.
        for (int n = 0; n < 600; n++) begin
            d = {$urandom, $urandom};
            sel = $urandom_range(0, 9);
            case (sel)
                0, 1, 2, 3: idx = I_CMD;
                4, 5: idx = I_LVL;
                6: idx = I_SLF;
                7: idx = I_ACK;
                default: begin
                    case ($urandom_range(0, 3))
                        0: idx = 12'h000;
                        1: idx = 12'h80A;
                        2: idx = 12'h832;
                        default: idx = 12'hFFF;
                    endcase
                end
            endcase
            if (idx == I_CMD) begin
                if ($urandom_range(0, 3) != 0) d = d & ~64'h0000_0000_FFF3_2000;
                if ($urandom_range(0, 1) != 0) d = d & ~64'h0000_0000_000C_9F00;
                else if ($urandom_range(0, 1) != 0) d = d & ~64'h0000_0000_000C_8F00 | 64'h1000;
            end else if ($urandom_range(0, 3) != 0) begin
                d = (idx == I_ACK) ? 64'h0 : {56'h0, d[7:0]};
            end
            do_write(idx, d);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule